// File: doc/BRIEF.md
# Calendar Alarm Match and Interrupt Controller

This block decides when a real-time clock raises an interrupt. On every minute boundary it compares the current BCD minute, hour, day-of-month and weekday with four stored alarm fields. It sets an alarm flag when all the fields that take part in the match agree. It also keeps a tick flag, which seconds or minutes can set, and a timer flag that an external countdown sets. It drives an active-low interrupt pin from these flags and their enables. The pin works in one of two modes: it can stay low while a condition is pending, or it can give a fixed-length low pulse for each event.

Software reaches the block through a plain register write strobe, which has an address and a data byte. Address 0x1 is the control/status register and addresses 0x9 to 0xC hold the alarm fields. Time counting and the serial host interface sit outside the block. The current time fields and the tick strobes come from a neighbouring counter, and the tick strobes are single-cycle. Every input and output is plain control or status with no valid/ready handshake, so there is no back-pressure. A write or a tick takes effect in the cycle in which it is asserted.

Top module: `cal_alarm_irq`

## Requirements
- R1: After reset the control/status output reads 0x00 and `irq_n` is high. All four alarm fields reset to 0x80, which means every field is excluded, so a minute tick does not set the alarm flag.
- R2: A write to address 0x1 loads enable bits 0 (timer enable), 1 (alarm enable), 4 (pulse mode), 6 (second-tick enable) and 7 (minute-tick enable) directly. For flag bits 2 (timer), 3 (alarm) and 5 (tick), writing 0 clears the flag and writing 1 leaves it unchanged.
- R3: On a cycle with `min_tick` high, alarm flag bit 3 becomes 1 on the next cycle if every included alarm field equals the current field under its mask. The masks are 0x7F for the minute field (address 0x9), 0x3F for hour (0xA), 0x3F for day-of-month (0xB) and 0x07 for weekday (0xC).
- R4: An alarm field with bit 7 set is excluded from the comparison. When all four fields are excluded, no match occurs.
- R5: The alarm flag never sets in a cycle without `min_tick`, even when the time fields match.
- R6: Tick flag bit 5 sets on `sec_tick` when bit 6 is 1, and on `min_tick` when bit 7 is 1. It does not set on a tick whose enable is 0.
- R7: `timer_expire` sets timer flag bit 2 on the next cycle.
- R8: Flags set whatever the state of their interrupt enables. The enables only gate the pin.
- R9: In level mode (bit 4 = 0), `irq_n` is low exactly while (alarm flag and alarm enable), or (timer flag and timer enable), or (tick flag and either tick enable) holds.
- R10: In pulse mode (bit 4 = 1), an enabled flag-set event drives `irq_n` low for PULSE_CYCLES cycles, starting on the cycle in which the flag appears. The pin then returns high even if the flag stays set.
- R11: When a flag-set event and a control write of 0 to that flag fall in the same cycle, the flag ends up set.
- R12: Writes to addresses other than 0x1 and 0x9 to 0xC leave the control/status value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_min | input | 8 | Current minute, BCD |
| cur_hour | input | 8 | Current hour, BCD |
| cur_mday | input | 8 | Current day of month, BCD |
| cur_wday | input | 8 | Current weekday, 0 to 6 |
| sec_tick | input | 1 | One-cycle strobe on each second |
| min_tick | input | 1 | One-cycle strobe on each minute boundary |
| timer_expire | input | 1 | One-cycle strobe from the countdown timer |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| ctrl_q | output | 8 | Control/status register value |
| irq_n | output | 1 | Active-low interrupt pin |

## Verification
A corrupted alarm field or a wrong comparison mask shows up as a wrong alarm flag bit on `ctrl_q`. This appears one cycle after the first minute tick that follows the fault, so the bench walks a table of matching and near-miss times and checks bit 3 straight after each tick. A flag or enable that holds the wrong value shows up on `irq_n` in the same cycle in level mode. A stuck or mis-loaded pulse counter changes the length of the low pulse, so the bench counts that pulse cycle by cycle.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int REG_W    = 8;
  localparam int ADDR_W   = 4;
  localparam int N_FIELDS = 4;

  localparam logic [ADDR_W-1:0] CTRL_ADDR  = 4'h1;
  localparam logic [ADDR_W-1:0] ALARM_BASE = 4'h9;

  // control/status bit positions (decoded by software, keep fixed)
  localparam int B_TIE   = 0;
  localparam int B_AIE   = 1;
  localparam int B_TF    = 2;
  localparam int B_AF    = 3;
  localparam int B_PULSE = 4;
  localparam int B_MSF   = 5;
  localparam int B_SIE   = 6;
  localparam int B_MIE   = 7;

  localparam int IGNORE_BIT = REG_W - 1;

  localparam logic [REG_W-1:0] FLAG_BITS =
    (REG_W'(1) << B_TF) | (REG_W'(1) << B_AF) | (REG_W'(1) << B_MSF);

  // per-field compare mask: minute, hour, day of month, weekday
  function automatic logic [REG_W-1:0] field_mask(input int idx);
    case (idx)
      0:       return 8'h7F;
      1, 2:    return 8'h3F;
      default: return 8'h07;
    endcase
  endfunction
endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
  import cal_alarm_pkg::*;
#(
  parameter int NF = N_FIELDS,
  parameter int AW = ADDR_W,
  parameter int DW = REG_W,
  parameter logic [AW-1:0] BASE = ALARM_BASE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [NF*DW-1:0] alm_flat
);
  localparam logic [DW-1:0] RST_VAL = DW'(1) << (DW - 1);

  for (genvar i = 0; i < NF; i++) begin : g_field
    logic [DW-1:0] q;
    logic          hit;
    assign hit = wr_en && (wr_addr == BASE + AW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)   q <= RST_VAL;
      else if (hit) q <= wr_data;
    end
    assign alm_flat[i*DW +: DW] = q;
  end
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
#(
  parameter int NF = N_FIELDS,
  parameter int DW = REG_W
) (
  input  logic [NF*DW-1:0] alm_flat,
  input  logic [NF*DW-1:0] cur_flat,
  output logic             hit
);
  logic [NF-1:0] used_v;
  logic [NF-1:0] same_v;

  for (genvar i = 0; i < NF; i++) begin : g_cmp
    localparam logic [DW-1:0] MSK = DW'(field_mask(i));
    assign used_v[i] = ~alm_flat[i*DW + IGNORE_BIT];
    assign same_v[i] = ((alm_flat[i*DW +: DW] & MSK) == (cur_flat[i*DW +: DW] & MSK));
  end

  // at least one field takes part, and every participating field agrees
  assign hit = (|used_v) && (&(same_v | ~used_v));
endmodule

// File: rtl/cal_ctrl_flags.sv
module cal_ctrl_flags
  import cal_alarm_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          sec_tick,
  input  logic          min_tick,
  input  logic          timer_expire,
  input  logic          alarm_hit,
  output logic [DW-1:0] ctrl_q,
  output logic          fire
);
  logic          set_af, set_tf, set_msf, ctrl_wr;
  logic [DW-1:0] base, set_vec, ctrl_d;

  always_comb begin
    set_af  = min_tick & alarm_hit;
    set_tf  = timer_expire;
    set_msf = (sec_tick & ctrl_q[B_SIE]) | (min_tick & ctrl_q[B_MIE]);
    ctrl_wr = wr_en && (wr_addr == CTRL_ADDR);

    // enables take the written value; flags only clear on a written 0
    if (ctrl_wr) base = (wr_data & ~FLAG_BITS) | (wr_data & ctrl_q & FLAG_BITS);
    else         base = ctrl_q;

    set_vec         = '0;
    set_vec[B_AF]   = set_af;
    set_vec[B_TF]   = set_tf;
    set_vec[B_MSF]  = set_msf;
    ctrl_d          = base | set_vec;   // a set event beats a clearing write

    fire = (set_af & ctrl_q[B_AIE]) | (set_tf & ctrl_q[B_TIE]) | set_msf;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/cal_irq_out.sv
module cal_irq_out
  import cal_alarm_pkg::*;
#(
  parameter int DW           = REG_W,
  parameter int PULSE_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ctrl_q,
  input  logic          fire,
  output logic          irq_n
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          pending;

  assign pending = (ctrl_q[B_AF] & ctrl_q[B_AIE]) |
                   (ctrl_q[B_TF] & ctrl_q[B_TIE]) |
                   (ctrl_q[B_MSF] & (ctrl_q[B_SIE] | ctrl_q[B_MIE]));

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (fire)     cnt <= CW'(PULSE_CYCLES);
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end

  assign irq_n = ctrl_q[B_PULSE] ? (cnt == '0) : !pending;
endmodule

// File: rtl/cal_alarm_irq.sv
module cal_alarm_irq
  import cal_alarm_pkg::*;
#(
  parameter int PULSE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  cur_min,
  input  logic [REG_W-1:0]  cur_hour,
  input  logic [REG_W-1:0]  cur_mday,
  input  logic [REG_W-1:0]  cur_wday,
  input  logic              sec_tick,
  input  logic              min_tick,
  input  logic              timer_expire,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  ctrl_q,
  output logic              irq_n
);
  localparam int FLAT_W = N_FIELDS * REG_W;

  logic [FLAT_W-1:0] alm_flat;
  logic [FLAT_W-1:0] cur_flat;
  logic              alarm_hit;
  logic              fire;

  assign cur_flat = {cur_wday, cur_mday, cur_hour, cur_min};

  cal_alarm_regs #(.NF(N_FIELDS), .AW(ADDR_W), .DW(REG_W), .BASE(ALARM_BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .alm_flat(alm_flat)
  );

  cal_alarm_match #(.NF(N_FIELDS), .DW(REG_W)) u_match (
    .alm_flat(alm_flat), .cur_flat(cur_flat), .hit(alarm_hit)
  );

  cal_ctrl_flags #(.AW(ADDR_W), .DW(REG_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sec_tick(sec_tick), .min_tick(min_tick),
    .timer_expire(timer_expire), .alarm_hit(alarm_hit),
    .ctrl_q(ctrl_q), .fire(fire)
  );

  cal_irq_out #(.DW(REG_W), .PULSE_CYCLES(PULSE_CYCLES)) u_irq (
    .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .fire(fire), .irq_n(irq_n)
  );
endmodule

// File: rtl/cal_alarm_irq_chk.sv
module cal_alarm_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sec_tick,
  input logic       min_tick,
  input logic       timer_expire,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic       wr_af_bit,
  input logic [7:0] ctrl_q,
  input logic       irq_n
);
  // R3 / R5: alarm flag only rises after a minute tick
  a_r5_af_needs_minute: assert property (@(posedge clk) disable iff (!rst_n)
    !min_tick |=> !$rose(ctrl_q[3]));

  // R6: tick flag only rises after a second or minute tick
  a_r6_msf_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !(sec_tick || min_tick) |=> !$rose(ctrl_q[5]));

  // R2: writing 1 to a set alarm flag keeps it
  a_r2_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'h1 && wr_af_bit && ctrl_q[3]) |=> ctrl_q[3]);

  // R7: timer strobe sets the timer flag
  a_r7_timer_sets: assert property (@(posedge clk) disable iff (!rst_n)
    timer_expire |=> ctrl_q[2]);

  // R9: level-mode pin follows the enabled flags
  a_r9_level_pin: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[4] |-> (irq_n == !((ctrl_q[3] && ctrl_q[1]) || (ctrl_q[2] && ctrl_q[0]) ||
                               (ctrl_q[5] && (ctrl_q[6] || ctrl_q[7])))));
endmodule

bind cal_alarm_irq cal_alarm_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .min_tick(min_tick),
  .timer_expire(timer_expire), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_af_bit(wr_data[3]), .ctrl_q(ctrl_q), .irq_n(irq_n)
);

// File: tb/tb_cal_alarm_irq.sv
module tb_cal_alarm_irq;
  localparam int PULSE = 4;
  localparam int NVEC  = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cur_min = '0, cur_hour = '0, cur_mday = 8'h01, cur_wday = '0;
  logic       sec_tick = 1'b0, min_tick = 1'b0, timer_expire = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] ctrl_q;
  logic       irq_n;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  cal_alarm_irq #(.PULSE_CYCLES(PULSE)) dut (
    .clk(clk), .rst_n(rst_n), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_mday(cur_mday), .cur_wday(cur_wday), .sec_tick(sec_tick),
    .min_tick(min_tick), .timer_expire(timer_expire), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ctrl_q(ctrl_q), .irq_n(irq_n)
  );

  // {expected alarm flag, alarm mn/hr/dm/wd, current mn/hr/dm/wd}
  localparam logic [64:0] VEC [NVEC] = '{
    {1'b1, 32'h30121503, 32'h30121503},
    {1'b0, 32'h30121503, 32'h31121503},
    {1'b1, 32'h30808080, 32'h30070105},
    {1'b0, 32'h80808080, 32'h00000100},
    {1'b1, 32'h80238006, 32'h45232806},
    {1'b0, 32'h80238006, 32'h45232805},
    {1'b1, 32'h80088080, 32'h00C80100},
    {1'b1, 32'h80808006, 32'h000001FE},
    {1'b1, 32'h00003180, 32'h00003102},
    {1'b0, 32'h00003180, 32'h00013102}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_alarm(input logic [31:0] v);
    wr_reg(4'h9, v[31:24]);
    wr_reg(4'hA, v[23:16]);
    wr_reg(4'hB, v[15:8]);
    wr_reg(4'hC, v[7:0]);
  endtask

  task automatic set_time(input logic [31:0] v);
    cur_min = v[31:24]; cur_hour = v[23:16]; cur_mday = v[15:8]; cur_wday = v[7:0];
  endtask

  task automatic pulse_min();
    @(negedge clk); min_tick = 1'b1;
    @(negedge clk); min_tick = 1'b0;
  endtask

  task automatic pulse_sec();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state and all fields excluded
    check("R1 ctrl", ctrl_q, 8'h00);
    check("R1 irq", {7'd0, irq_n}, 8'h01);
    set_time(32'h00000100);
    pulse_min();
    check("R1 no match after reset", ctrl_q, 8'h00);

    // R3/R4/R8: table of alarm and time patterns
    for (int i = 0; i < NVEC; i++) begin
      wr_reg(4'h1, 8'h00);
      set_alarm(VEC[i][63:32]);
      set_time(VEC[i][31:0]);
      pulse_min();
      check($sformatf("R3 R4 vec%0d flag", i), {7'd0, ctrl_q[3]}, {7'd0, VEC[i][64]});
      check($sformatf("R8 vec%0d pin gated", i), {7'd0, irq_n}, 8'h01);
    end

    // R5: matching time but only a second tick
    wr_reg(4'h1, 8'h00);
    set_alarm(32'h30121503);
    set_time(32'h30121503);
    pulse_sec();
    check("R5 no match on second", ctrl_q, 8'h00);

    // R2: enables load, flag write-1 keeps, write-0 clears
    pulse_min();
    check("R2 flag set", ctrl_q, 8'h08);
    wr_reg(4'h1, 8'h1B);
    check("R2 keep with 1", ctrl_q, 8'h1B);
    wr_reg(4'h1, 8'h13);
    check("R2 clear with 0", ctrl_q, 8'h13);
    wr_reg(4'h1, 8'h00);
    check("R2 all clear", ctrl_q, 8'h00);

    // R12: other addresses have no effect on ctrl
    wr_reg(4'h0, 8'hFF);
    wr_reg(4'hD, 8'hFF);
    check("R12 ignored writes", ctrl_q, 8'h00);

    // R9: level mode
    wr_reg(4'h1, 8'h02);
    pulse_min();
    check("R9 level ctrl", ctrl_q, 8'h0A);
    check("R9 level low", {7'd0, irq_n}, 8'h00);
    wr_reg(4'h1, 8'h08);
    check("R9 enable off high", {7'd0, irq_n}, 8'h01);
    wr_reg(4'h1, 8'h0A);
    check("R9 enable on low", {7'd0, irq_n}, 8'h00);
    wr_reg(4'h1, 8'h02);
    check("R9 flag cleared high", {7'd0, irq_n}, 8'h01);

    // R6: tick flag
    wr_reg(4'h1, 8'h40);
    pulse_sec();
    check("R6 sec sets", ctrl_q, 8'h60);
    check("R9 tick low", {7'd0, irq_n}, 8'h00);
    wr_reg(4'h1, 8'h40);
    check("R6 clear", ctrl_q, 8'h40);
    set_time(32'h59121503);
    pulse_min();
    check("R6 min ignored without enable", ctrl_q, 8'h40);
    wr_reg(4'h1, 8'h80);
    pulse_min();
    check("R6 min sets", ctrl_q[5:5] == 1'b1 ? 8'h01 : 8'h00, 8'h01);
    wr_reg(4'h1, 8'h00);
    pulse_sec();
    check("R6 sec ignored without enable", ctrl_q, 8'h00);

    // R7: timer flag
    wr_reg(4'h1, 8'h01);
    @(negedge clk); timer_expire = 1'b1;
    @(negedge clk); timer_expire = 1'b0;
    check("R7 timer flag", ctrl_q, 8'h05);
    check("R7 timer pin", {7'd0, irq_n}, 8'h00);
    wr_reg(4'h1, 8'h00);
    check("R7 timer clear", ctrl_q, 8'h00);

    // R11: set beats a clearing write in the same cycle
    set_time(32'h30121503);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'h1; wr_data = 8'h00; min_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; min_tick = 1'b0;
    check("R11 set wins", ctrl_q, 8'h08);

    // R10: pulse mode
    wr_reg(4'h1, 8'h12);
    check("R10 idle high", {7'd0, irq_n}, 8'h01);
    pulse_min();
    check("R10 flag", ctrl_q, 8'h1A);
    check("R10 pulse start", {7'd0, irq_n}, 8'h00);
    for (int k = 1; k < PULSE; k++) begin
      @(negedge clk);
      check($sformatf("R10 pulse cycle %0d", k), {7'd0, irq_n}, 8'h00);
    end
    @(negedge clk);
    check("R10 pulse end", {7'd0, irq_n}, 8'h01);
    check("R10 flag held", ctrl_q, 8'h1A);

    finish_run();
  end
endmodule